// File: doc/BRIEF.md
# Table Jump Instruction Expander

This block sits in the decode path of a 32-bit embedded core with no address translation, just after the compressed-instruction decoder. Most instructions pass through it in the same cycle and are not changed. When the upstream decoder marks an instruction as a table jump and does not mark it illegal, the block takes an 8-bit index from the instruction and adds it to the jump-table base supplied by a CSR. It then reads that table word over a request/grant/response port into the data cache, and holds fetch stalled until the word returns.

In the cycle the response arrives, the block emits a 32-bit JAL in place of the compressed instruction. The JAL immediate is the fetched target minus the current PC. The destination register is x0 for low indices and x1, the return-address register, for high indices. The branch logic downstream treats this JAL as always mispredicted, so the pipeline is always redirected to the table target. Upstream keeps the instruction, PC and flags stable for as long as stall is high.

Top module: `tbl_jump_expander`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_stall_o` and `mem_req_o` are 0.
- R2: An instruction with `is_tj_i`=0, or with `is_tj_i`=1 and `illegal_i`=1, is passed through in the same cycle: `instr_o`=`instr_i`, `illegal_o`=`illegal_i`, `is_comp_o`=`is_comp_i`. Stall and request stay 0.
- R3: A legal table jump seen while idle raises `fetch_stall_o` in that same cycle. In the next cycle `mem_req_o` is 1 with `mem_addr_o` = (`jvt_base_i` with bits [5:0] cleared) + 4 × index. The index is `instr_i[9:2]`.
- R4: `mem_req_o` stays high with a stable address until the cycle in which `mem_gnt_i` is 1. It is low from the following cycle, so each table jump makes exactly one read.
- R5: From the start cycle until the response cycle, `fetch_stall_o` is 1, `instr_o` is the NOP 0x00000013, `illegal_o` is 0, and `is_comp_o` follows `is_comp_i`.
- R6: In the cycle `mem_rvalid_i` is 1, `fetch_stall_o` is 0 and `instr_o` is a JAL (opcode bits [6:0] = 1101111). Its rd field (bits [11:7]) is 0 when the index is 0 to 31 and 1 when the index is 32 to 255. Its immediate, in JAL bit order, equals bits [20:1] of (`mem_rdata_i` − `pc_i`). `illegal_o` is 0 and `is_comp_o` is 1.
- R7: After the response cycle the block is idle again, and a table jump presented in the very next cycle starts a new read.
- R8: The table address is computed modulo 2^AW, so a base near the top of the address space wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction from the compressed decoder |
| pc_i | input | AW | PC of the instruction |
| is_tj_i | input | 1 | Instruction is a table jump |
| illegal_i | input | 1 | Instruction is illegal |
| is_comp_i | input | 1 | Instruction was compressed |
| jvt_base_i | input | AW | Jump-table base from the CSR |
| instr_o | output | 32 | Instruction to decode |
| illegal_o | output | 1 | Illegal flag to decode |
| is_comp_o | output | 1 | Compressed flag to decode |
| fetch_stall_o | output | 1 | Holds fetch while a table read is pending |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | AW | Physical address of the table word |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | AW | Table word (jump target) |

## Verification
The assertions assume that upstream holds `instr_i`, `pc_i`, `jvt_base_i` and the flags steady while stall is high. They also assume that the cache answers only after granting, with a single response per grant. The stimulus keeps to these rules because one driver task holds each instruction until it sees stall drop, and one memory responder grants and answers exactly once per request. The grant and response delays are varied across runs, from zero up to several cycles.

// File: rtl/tbl_jump_expander.sv
module tbl_jump_expander #(
  parameter int unsigned AW         = 32,
  parameter int unsigned IDX_LSB    = 2,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned LINK_FIRST = 32,
  parameter int unsigned BASE_ALIGN = 6,
  parameter int unsigned ENT_SHIFT  = 2,
  parameter int unsigned LINK_REG   = 1,
  parameter logic [31:0] NOP_WORD   = 32'h0000_0013
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   instr_i,
  input  logic [AW-1:0] pc_i,
  input  logic          is_tj_i,
  input  logic          illegal_i,
  input  logic          is_comp_i,
  input  logic [AW-1:0] jvt_base_i,
  output logic [31:0]   instr_o,
  output logic          illegal_o,
  output logic          is_comp_o,
  output logic          fetch_stall_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i
);
  localparam int unsigned OFF_W = 21;
  localparam logic [6:0]  JAL_OP = 7'b1101111;

  typedef enum logic {S_IDLE, S_WAIT} st_t;

  st_t           st_q;
  logic          gnt_q;
  logic          link_q;
  logic [AW-1:0] addr_q;

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    entry_addr;
  logic [AW-1:0]    off;
  logic [4:0]       rd;
  logic [31:0]      jal_word;
  logic             start, done;

  assign idx        = instr_i[IDX_LSB +: IDX_W];
  assign entry_addr = {jvt_base_i[AW-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}}
                    + (AW'(idx) << ENT_SHIFT);
  assign start      = (st_q == S_IDLE) && is_tj_i && !illegal_i;
  assign done       = (st_q == S_WAIT) && mem_rvalid_i;

  assign off      = mem_rdata_i - pc_i;
  assign rd       = link_q ? 5'(LINK_REG) : 5'd0;
  assign jal_word = {off[20], off[10:1], off[11], off[19:12], rd, JAL_OP};

  logic unused_bits;
  assign unused_bits = ^{jvt_base_i[BASE_ALIGN-1:0], off[AW-1:OFF_W], off[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      gnt_q  <= 1'b0;
      link_q <= 1'b0;
      addr_q <= '0;
    end else if (start) begin
      st_q   <= S_WAIT;
      gnt_q  <= 1'b0;
      link_q <= (32'(idx) >= LINK_FIRST);
      addr_q <= entry_addr;
    end else if (done) begin
      st_q   <= S_IDLE;
      gnt_q  <= 1'b0;
    end else if (mem_req_o && mem_gnt_i) begin
      gnt_q  <= 1'b1;
    end
  end

  assign mem_req_o     = (st_q == S_WAIT) && !gnt_q;
  assign mem_addr_o    = addr_q;
  assign fetch_stall_o = start || ((st_q == S_WAIT) && !mem_rvalid_i);

  always_comb begin
    if (done) begin
      instr_o   = jal_word;
      illegal_o = 1'b0;
      is_comp_o = 1'b1;
    end else if (fetch_stall_o) begin
      instr_o   = NOP_WORD;
      illegal_o = 1'b0;
      is_comp_o = is_comp_i;
    end else begin
      instr_o   = instr_i;
      illegal_o = illegal_i;
      is_comp_o = is_comp_i;
    end
  end
endmodule

// File: rtl/tbl_jump_expander_chk.sv
module tbl_jump_expander_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [31:0]   instr_i,
  input logic          is_tj_i,
  input logic          illegal_i,
  input logic          is_comp_i,
  input logic [31:0]   instr_o,
  input logic          illegal_o,
  input logic          is_comp_o,
  input logic          fetch_stall_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_gnt_i,
  input logic          mem_rvalid_i
);
  a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!is_tj_i || illegal_i) && !fetch_stall_o && !mem_rvalid_i)
      |-> (instr_o == instr_i && illegal_o == illegal_i && is_comp_o == is_comp_i));

  a_r3_req_after_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_stall_o) |=> mem_req_o);

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r4_req_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> !mem_req_o);

  a_r5_stall_covers_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> fetch_stall_o);

  a_r6_emit_jal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_stall_o && is_tj_i && !illegal_i)
      |-> (instr_o[6:0] == 7'b1101111 && !illegal_o && is_comp_o));
endmodule

bind tbl_jump_expander tbl_jump_expander_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .is_tj_i(is_tj_i),
  .illegal_i(illegal_i), .is_comp_i(is_comp_i), .instr_o(instr_o),
  .illegal_o(illegal_o), .is_comp_o(is_comp_o), .fetch_stall_o(fetch_stall_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
  .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/tb_tbl_jump_expander.sv
`timescale 1ns/1ps
module tb_tbl_jump_expander;
  localparam int AW = 32;

  logic          clk_i = 0, rst_ni = 0;
  logic [31:0]   instr_i = 0;
  logic [AW-1:0] pc_i = 0, jvt_base_i = 0, mem_rdata_i = 0;
  logic          is_tj_i = 0, illegal_i = 0, is_comp_i = 0;
  logic          mem_gnt_i = 0, mem_rvalid_i = 0;
  logic [31:0]   instr_o;
  logic          illegal_o, is_comp_o, fetch_stall_o, mem_req_o;
  logic [AW-1:0] mem_addr_o;

  tbl_jump_expander #(.AW(AW)) dut (.*);

  always #5 clk_i = ~clk_i;

  int vectors = 0, miscompares = 0, cycles = 0;
  int gnt_dly = 0, rsp_dly = 0;
  bit done_flag = 0;

  function automatic logic [AW-1:0] table_word(input logic [AW-1:0] a);
    return (a * 32'd2654435761) ^ 32'h0003_4000;
  endfunction

  // memory responder
  int gnt_cnt = 0, rsp_cnt = 0;
  bit rsp_pend = 0;
  logic [AW-1:0] rsp_addr = 0;
  always @(posedge clk_i) begin
    #1;
    mem_gnt_i = 0; mem_rvalid_i = 0;
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        mem_rvalid_i = 1; mem_rdata_i = table_word(rsp_addr); rsp_pend = 0;
      end else rsp_cnt--;
    end else if (mem_req_o && rst_ni) begin
      if (gnt_cnt >= gnt_dly) begin
        mem_gnt_i = 1; rsp_pend = 1; rsp_cnt = rsp_dly; rsp_addr = mem_addr_o; gnt_cnt = 0;
      end else gnt_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model, compared every cycle
  bit m_busy = 0, m_gnt = 0, m_link = 0, m_first = 1;
  logic [AW-1:0] m_addr = 0;
  always @(negedge clk_i) begin
    logic legal;
    int idx;
    cycles++;
    if (!rst_ni) begin
      check(!fetch_stall_o, "R1 stall in reset", 64'(fetch_stall_o), 0);
      check(!mem_req_o, "R1 req in reset", 64'(mem_req_o), 0);
      m_busy = 0; m_gnt = 0; m_first = 1;
    end else begin
      legal = is_tj_i && !illegal_i;
      idx = int'(instr_i[9:2]);
      if (m_first) check(!mem_req_o, "R1 req after reset", 64'(mem_req_o), 0);
      check(mem_req_o == (m_busy && !m_gnt), "R4 request level", 64'(mem_req_o), 64'(m_busy && !m_gnt));
      if (mem_req_o) check(mem_addr_o == m_addr, "R3 table address", 64'(mem_addr_o), 64'(m_addr));
      if (!m_busy && !legal) begin
        check(!fetch_stall_o, "R2 stall", 64'(fetch_stall_o), 0);
        check(instr_o == instr_i && illegal_o == illegal_i && is_comp_o == is_comp_i,
              "R2 pass-through", {31'd0, illegal_o, instr_o}, {31'd0, illegal_i, instr_i});
      end else if (m_busy && mem_rvalid_i) begin
        logic [AW-1:0] off;
        logic [20:0] imm;
        off = mem_rdata_i - pc_i;
        imm = {instr_o[31], instr_o[19:12], instr_o[20], instr_o[30:21], 1'b0};
        check(!fetch_stall_o, "R6 stall released", 64'(fetch_stall_o), 0);
        check(instr_o[6:0] == 7'h6f, "R6 opcode", 64'(instr_o[6:0]), 64'h6f);
        check(instr_o[11:7] == (m_link ? 5'd1 : 5'd0), "R6 rd", 64'(instr_o[11:7]), 64'(m_link));
        check(imm == {off[20:1], 1'b0}, "R6 immediate", 64'(imm), 64'({off[20:1], 1'b0}));
        check(!illegal_o && is_comp_o, "R6 flags", {illegal_o, is_comp_o}, 64'b01);
      end else begin
        check(fetch_stall_o, "R5 stall held", 64'(fetch_stall_o), 1);
        check(instr_o == 32'h13 && !illegal_o && is_comp_o == is_comp_i, "R5 nop while stalled",
              64'(instr_o), 64'h13);
      end
      // next-state update (inputs stay stable until after the edge)
      if (!m_busy && legal) begin
        m_busy = 1; m_gnt = 0; m_link = (idx >= 32);
        m_addr = (jvt_base_i & ~AW'(63)) + AW'(idx * 4);
      end else if (m_busy) begin
        if (mem_rvalid_i) begin m_busy = 0; m_gnt = 0; end
        else if (mem_req_o && mem_gnt_i) m_gnt = 1;
      end
      m_first = 0;
    end
  end

  task automatic apply(input logic [31:0] ins, input logic [AW-1:0] pc, input bit tj, input bit ill,
                       input bit comp, input logic [AW-1:0] base);
    @(posedge clk_i); #1;
    instr_i = ins; pc_i = pc; is_tj_i = tj; illegal_i = ill; is_comp_i = comp; jvt_base_i = base;
    forever begin
      @(negedge clk_i); #1;
      if (!fetch_stall_o) break;
    end
  endtask

  function automatic logic [31:0] tj_word(input int idx);
    return {16'h0, 3'b101, 3'b000, 8'(idx), 2'b10};
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    apply(32'h0050_0093, 32'h100, 0, 0, 0, 32'h8000_0000);       // R2 plain instruction
    apply(32'h0000_4502, 32'h104, 0, 0, 1, 32'h8000_0000);       // R2 compressed non-jump
    apply(tj_word(7), 32'h106, 1, 1, 1, 32'h8000_0000);          // R2 illegal table jump
    gnt_dly = 0; rsp_dly = 0;
    apply(tj_word(5), 32'h2000, 1, 0, 1, 32'h8000_0040);         // R3 R6 plain form
    apply(tj_word(31), 32'h2002, 1, 0, 1, 32'h8000_007F);        // R6 last plain index, low base bits
    gnt_dly = 3; rsp_dly = 2;
    apply(tj_word(32), 32'h2004, 1, 0, 1, 32'h8000_0040);        // R6 first link index
    apply(tj_word(255), 32'hFFFF_0000, 1, 0, 1, 32'h1234_5600);  // R6 top index
    gnt_dly = 1; rsp_dly = 5;
    apply(tj_word(0), 32'h7FFF_FFFE, 1, 0, 1, 32'h0000_0000);    // R4 index zero
    apply(tj_word(200), 32'h10, 1, 0, 1, 32'hFFFF_FFC0);         // R8 wrap
    gnt_dly = 0; rsp_dly = 0;
    apply(tj_word(40), 32'h3000, 1, 0, 1, 32'h4000_0000);        // R7 back-to-back
    apply(tj_word(3), 32'h3002, 1, 0, 1, 32'h4000_0000);         // R7
    apply(32'h0000_0013, 32'h3004, 0, 0, 0, 32'h4000_0000);      // R7 idle afterwards
    for (int i = 0; i < 20; i++) begin
      gnt_dly = i % 4; rsp_dly = (i * 3) % 5;
      apply(tj_word((i * 37) % 256), 32'h5000 + 32'(i * 2), 1, 0, 1, 32'h6000_0000 + 32'(i * 52));
      apply(32'h00A0_0513 + 32'(i), 32'h6000 + 32'(i * 4), 0, 0, 0, 32'h0);
    end
    repeat (3) @(posedge clk_i);
    done_flag = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done_flag) begin
      vectors++; miscompares++;
      $display("FAIL watchdog R5 stall never released actual=1 expected=0");
      finish_run();
    end
  end
endmodule